// File: doc/BRIEF.md
# Interrupt Controller Virtualization Configuration Registers

This block holds the small configuration space that lets a hypervisor-aware interrupt controller choose how it routes interrupts. It has a fixed capability word and one writable configuration/status word. Three status bits go to the routing logic as plain level signals: routing enable, interrupt-number encoding and CPU-number encoding. The block accepts a write to the configuration word only under its locking rule. When accepted, the stored value is filtered through the capability word. While routing is enabled, a write is accepted only if it is zero.

A 32-bit register port reaches the block. The port has valid/ready on the request side and on the response side. Only one access is in flight at a time. The response comes one cycle after the request is accepted and stays stable until it is taken. While a response waits, `req_ready` stays low, so a slow consumer holds back new requests. A second 64-bit view serves a platform miscellaneous-function register. It shows the enable and interrupt-encode bits at high bit positions. A write through this view can set those two bits, and the same locking rule applies.

A build-time parameter removes the extension. In that build the routing enable is fixed on and no configuration can be changed.

Top module: `vext_cfg_regs`

## Requirements
- R1: After reset, with the extension present, the configuration word is zero, so all three routing outputs are low (legacy routing). `rsp_valid` is low, `req_ready` is high and `misc_rdata` is zero.
- R2: A read at byte offset 0x0 returns the capability word 0x0000000F. Its bits are: bit 0 extension present, bit 1 enable option, bit 2 interrupt encode, bit 3 CPU encode. A read at offset 0x4 returns the current configuration word. Neither read reports an error.
- R3: A write to offset 0x0 responds with `rsp_err`=1 and changes no state.
- R4: A write to offset 0x4 with a nonzero value while configuration bit 1 (enable) is set responds with an error and leaves the word unchanged. A zero write in that state is accepted and clears the word.
- R5: An accepted write to offset 0x4 stores the written value ANDed with the capability word and responds without error. `route_en`, `route_int_enc` and `route_cpu_enc` follow configuration bits 1, 2 and 3.
- R6: `misc_rdata` has bit 48 equal to configuration bit 1 and bit 49 equal to configuration bit 2. All other bits of `misc_rdata` are zero.
- R7: A `misc_we` cycle ORs bit 1 into the configuration word when `misc_wdata[48]` is 1, and ORs bit 2 when `misc_wdata[49]` is 1. The result passes through the same lock and mask rules as a bus write, so it is dropped while enable is set. If a bus write to offset 0x4 is accepted in the same cycle, the bus write wins and the `misc_we` is ignored.
- R8: Any other offset, including a misaligned one, reads as zero without error. A write to such an offset responds without error and has no effect.
- R9: The response appears on the cycle after acceptance. Data and error are held while `rsp_ready` is low, and `req_ready` is low during that time.
- R10: With the extension parameter off, the block behaves as follows. Offset 0x0 reads zero. Offset 0x4 reads 0x2. Writes to either offset respond with an error. `route_en` is high. `misc_rdata` has only bit 48 set. `misc_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| rsp_err | output | 1 | Access error |
| misc_we | input | 1 | Miscellaneous-function view write strobe |
| misc_wdata | input | MISC_W | Miscellaneous-function write value |
| misc_rdata | output | MISC_W | Miscellaneous-function read value |
| route_en | output | 1 | Extended routing enable |
| route_int_enc | output | 1 | Interrupt-number encoding enable |
| route_cpu_enc | output | 1 | CPU-number encoding enable |

## Verification
A wrong stored configuration word shows at the routing outputs and at `misc_rdata` on the cycle after the write that produced it, with no wait for a read. A lock that fails to hold shows the same way: the outputs change after a nonzero write while enabled, and the error response on that write is missing. A broken response register shows as data or error changing during a stall, or as `req_ready` rising before the response has been taken.

// File: rtl/vext_pkg.sv
package vext_pkg;
  localparam int unsigned OFS_CAPS = 32'h0;
  localparam int unsigned OFS_CFG  = 32'h4;

  localparam int unsigned B_PRESENT = 0;
  localparam int unsigned B_EN      = 1;
  localparam int unsigned B_INTENC  = 2;
  localparam int unsigned B_CPUENC  = 3;

  function automatic logic [31:0] caps_word(input bit has_ext);
    logic [31:0] w;
    w = '0;
    if (has_ext) begin
      w[B_PRESENT] = 1'b1;
      w[B_EN]      = 1'b1;
      w[B_INTENC]  = 1'b1;
      w[B_CPUENC]  = 1'b1;
    end
    return w;
  endfunction
endpackage

// File: rtl/vext_bus_port.sv
module vext_bus_port #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic [DATA_W-1:0] caps,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic              cfg_reject,
  output logic              cfg_wr,
  output logic [DATA_W-1:0] cfg_wdata
);
  import vext_pkg::*;

  localparam logic [ADDR_W-1:0] A_CAPS = ADDR_W'(OFS_CAPS);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);

  logic accept, hit_caps, hit_cfg;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign hit_caps  = (req_addr == A_CAPS);
  assign hit_cfg   = (req_addr == A_CFG);
  assign cfg_wr    = accept && req_write && hit_cfg;
  assign cfg_wdata = req_wdata;

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      if (hit_caps)     rd_mux = caps;
      else if (hit_cfg) rd_mux = cfg_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
      rsp_err   <= req_write && (hit_caps || (hit_cfg && cfg_reject));
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vext_cfg_store.sv
module vext_cfg_store #(
  parameter int unsigned DATA_W   = 32,
  parameter bit          HAS_VEXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              misc_wr,
  input  logic              misc_set_en,
  input  logic              misc_set_enc,
  output logic [DATA_W-1:0] caps,
  output logic [DATA_W-1:0] cfg_word,
  output logic              cfg_reject
);
  import vext_pkg::*;

  localparam logic [DATA_W-1:0] CAPS_ALL = DATA_W'(caps_word(1'b1));

  generate
    if (HAS_VEXT) begin : g_ext
      logic [DATA_W-1:0] word_q, misc_word;
      logic misc_reject;

      assign caps       = CAPS_ALL;
      assign cfg_word   = word_q;
      assign cfg_reject = word_q[B_EN] && (cfg_wdata != '0);

      always_comb begin
        misc_word = word_q;
        if (misc_set_en)  misc_word[B_EN]     = 1'b1;
        if (misc_set_enc) misc_word[B_INTENC] = 1'b1;
      end
      assign misc_reject = word_q[B_EN] && (misc_word != '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          word_q <= '0;
        else if (cfg_wr) begin
          if (!cfg_reject) word_q <= cfg_wdata & CAPS_ALL;
        end else if (misc_wr && !misc_reject)
          word_q <= misc_word & CAPS_ALL;
      end
    end else begin : g_legacy
      logic [DATA_W-1:0] fixed_word;
      always_comb begin
        fixed_word       = '0;
        fixed_word[B_EN] = 1'b1;
      end
      assign caps       = '0;
      assign cfg_word   = fixed_word;
      assign cfg_reject = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/vext_misc_view.sv
module vext_misc_view #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MISC_W   = 64,
  parameter int unsigned EN_POS   = 48,
  parameter int unsigned ENC_POS  = 49,
  parameter bit          HAS_VEXT = 1'b1
) (
  input  logic [DATA_W-1:0] cfg_word,
  input  logic              misc_we,
  input  logic [MISC_W-1:0] misc_wdata,
  output logic [MISC_W-1:0] misc_rdata,
  output logic              misc_wr,
  output logic              misc_set_en,
  output logic              misc_set_enc
);
  import vext_pkg::*;

  always_comb begin
    misc_rdata = '0;
    if (HAS_VEXT) begin
      misc_rdata[EN_POS]  = cfg_word[B_EN];
      misc_rdata[ENC_POS] = cfg_word[B_INTENC];
    end else begin
      misc_rdata[EN_POS]  = 1'b1;
    end
  end

  assign misc_wr      = HAS_VEXT && misc_we;
  assign misc_set_en  = misc_wdata[EN_POS];
  assign misc_set_enc = misc_wdata[ENC_POS];
endmodule

// File: rtl/vext_cfg_regs.sv
module vext_cfg_regs #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MISC_W   = 64,
  parameter int unsigned EN_POS   = 48,
  parameter int unsigned ENC_POS  = 49,
  parameter bit          HAS_VEXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic              misc_we,
  input  logic [MISC_W-1:0] misc_wdata,
  output logic [MISC_W-1:0] misc_rdata,
  output logic              route_en,
  output logic              route_int_enc,
  output logic              route_cpu_enc
);
  import vext_pkg::*;

  logic [DATA_W-1:0] caps, cfg_word, cfg_wdata;
  logic cfg_reject, cfg_wr, misc_wr, misc_set_en, misc_set_enc;

  vext_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_err,
    .caps, .cfg_word, .cfg_reject, .cfg_wr, .cfg_wdata
  );

  vext_cfg_store #(.DATA_W(DATA_W), .HAS_VEXT(HAS_VEXT)) u_store (
    .clk, .rst_n, .cfg_wr, .cfg_wdata, .misc_wr, .misc_set_en, .misc_set_enc,
    .caps, .cfg_word, .cfg_reject
  );

  vext_misc_view #(.DATA_W(DATA_W), .MISC_W(MISC_W), .EN_POS(EN_POS),
                   .ENC_POS(ENC_POS), .HAS_VEXT(HAS_VEXT)) u_misc (
    .cfg_word, .misc_we, .misc_wdata, .misc_rdata, .misc_wr,
    .misc_set_en, .misc_set_enc
  );

  assign route_en      = cfg_word[B_EN];
  assign route_int_enc = cfg_word[B_INTENC];
  assign route_cpu_enc = cfg_word[B_CPUENC];
endmodule

// File: rtl/vext_cfg_regs_chk.sv
module vext_cfg_regs_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MISC_W   = 64,
  parameter int unsigned EN_POS   = 48,
  parameter int unsigned ENC_POS  = 49,
  parameter bit          HAS_VEXT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic [MISC_W-1:0] misc_rdata,
  input logic              route_en,
  input logic              route_int_enc,
  input logic              route_cpu_enc
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
  a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  a_r3_caps_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr == ADDR_W'(0) |=> rsp_err);
  a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_addr == ADDR_W'(4) && route_en && req_wdata != '0
    |=> rsp_err && $stable(route_en) && $stable(route_int_enc) && $stable(route_cpu_enc));

  generate
    if (HAS_VEXT) begin : g_ext
      a_r5_store: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && req_addr == ADDR_W'(4) && !route_en
        |=> !rsp_err && route_en == $past(req_wdata[1])
            && route_int_enc == $past(req_wdata[2])
            && route_cpu_enc == $past(req_wdata[3]));
      a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        misc_rdata[EN_POS] == route_en && misc_rdata[ENC_POS] == route_int_enc);
    end else begin : g_legacy
      a_r10_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        route_en && misc_rdata[EN_POS]);
    end
  endgenerate
endmodule

bind vext_cfg_regs vext_cfg_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MISC_W(MISC_W),
  .EN_POS(EN_POS), .ENC_POS(ENC_POS), .HAS_VEXT(HAS_VEXT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .misc_rdata(misc_rdata), .route_en(route_en),
  .route_int_enc(route_int_enc), .route_cpu_enc(route_cpu_enc)
);

// File: tb/vext_cfg_regs_tb.sv
module vext_cfg_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0, misc_we = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [63:0] misc_wdata = '0;

  logic req_ready, rsp_valid, rsp_err, route_en, route_int_enc, route_cpu_enc;
  logic [31:0] rsp_rdata;
  logic [63:0] misc_rdata;
  logic l_req_ready, l_rsp_valid, l_rsp_err, l_en, l_ienc, l_cenc;
  logic [31:0] l_rsp_rdata;
  logic [63:0] l_misc_rdata;

  int checks = 0, failures = 0;
  logic [31:0] m_cfg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vext_cfg_regs u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_err, .misc_we, .misc_wdata,
    .misc_rdata, .route_en, .route_int_enc, .route_cpu_enc
  );

  vext_cfg_regs #(.HAS_VEXT(1'b0)) u_dut_legacy (
    .clk, .rst_n, .req_valid, .req_ready(l_req_ready), .req_write, .req_addr,
    .req_wdata, .rsp_valid(l_rsp_valid), .rsp_ready, .rsp_rdata(l_rsp_rdata),
    .rsp_err(l_rsp_err), .misc_we, .misc_wdata, .misc_rdata(l_misc_rdata),
    .route_en(l_en), .route_int_enc(l_ienc), .route_cpu_enc(l_cenc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_misc(input logic [31:0] c);
    logic [63:0] m;
    m = '0;
    m[48] = c[1];
    m[49] = c[2];
    return m;
  endfunction

  task automatic check_state(input string req);
    check({req, " route"}, {61'd0, route_cpu_enc, route_int_enc, route_en}, {61'd0, m_cfg[3:1]});
    check({req, " misc"}, misc_rdata, exp_misc(m_cfg));
    check("R10 legacy route_en", {63'd0, l_en}, 64'd1);
    check("R10 legacy misc", l_misc_rdata, 64'h0001_0000_0000_0000);
  endtask

  // one bus transfer, response stalled for 'stall' cycles
  task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d,
                      input int stall, input string req);
    logic [31:0] e_rd, l_rd;
    logic e_err, l_err;
    bit mapped_caps, mapped_cfg;
    mapped_caps = (a == 12'h0);
    mapped_cfg  = (a == 12'h4);
    e_rd = '0; l_rd = '0;
    if (!w && mapped_caps) begin e_rd = 32'hF; l_rd = 32'h0; end
    if (!w && mapped_cfg)  begin e_rd = m_cfg; l_rd = 32'h2; end
    e_err = w && (mapped_caps || (mapped_cfg && m_cfg[1] && d != 0));
    l_err = w && (mapped_caps || mapped_cfg);
    if (w && mapped_cfg && !(m_cfg[1] && d != 0)) m_cfg = d & 32'hF;
    @(negedge clk);
    check("R9 idle ready", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R9 rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
    check({req, " rdata"}, {32'd0, rsp_rdata}, {32'd0, e_rd});
    check({req, " err"}, {63'd0, rsp_err}, {63'd0, e_err});
    check("R10 legacy rdata", {32'd0, l_rsp_rdata}, {32'd0, l_rd});
    check("R10 legacy err", {63'd0, l_rsp_err}, {63'd0, l_err});
    check_state(req);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check("R9 stall valid", {63'd0, rsp_valid}, 64'd1);
      check("R9 stall ready", {63'd0, req_ready}, 64'd0);
      check("R9 stall data", {31'd0, rsp_err, rsp_rdata}, {31'd0, e_err, e_rd});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 consumed", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic misc_write(input logic set_en, input logic set_enc, input string req);
    logic [31:0] mv;
    mv = m_cfg;
    if (set_en)  mv[1] = 1'b1;
    if (set_enc) mv[2] = 1'b1;
    if (!m_cfg[1]) m_cfg = mv & 32'hF;
    @(negedge clk);
    misc_we = 1'b1;
    misc_wdata = {$urandom, $urandom};
    misc_wdata[48] = set_en;
    misc_wdata[49] = set_enc;
    @(negedge clk);
    misc_we = 1'b0;
    check_state(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240511);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R1 req_ready", {63'd0, req_ready}, 64'd1);
    check("R1 misc zero", misc_rdata, 64'd0);
    check_state("R1");

    // R2 reads
    xfer(1'b0, 12'h0, 32'h0, 0, "R2 caps read");
    xfer(1'b0, 12'h4, 32'h0, 1, "R2 cfg read");
    // R3 caps write
    xfer(1'b1, 12'h0, 32'hFFFF_FFFF, 0, "R3 caps write");
    // R5 masked store, no enable
    xfer(1'b1, 12'h4, 32'hFFFF_FFFD, 0, "R5 masked store");
    xfer(1'b0, 12'h4, 32'h0, 2, "R5 readback");
    // R7 misc sets enable, then R4 lock
    misc_write(1'b1, 1'b1, "R7 misc set");
    xfer(1'b1, 12'h4, 32'h0000_0008, 0, "R4 locked write");
    misc_write(1'b0, 1'b0, "R7 misc while enabled");
    xfer(1'b1, 12'h4, 32'h0, 0, "R4 zero unlock");
    // R8 unmapped and misaligned
    xfer(1'b0, 12'h5, 32'h0, 0, "R8 misaligned read");
    xfer(1'b1, 12'h8, 32'h1234_5678, 0, "R8 unmapped write");
    xfer(1'b0, 12'hFFC, 32'h0, 1, "R8 unmapped read");

    // R7 same-cycle conflict: bus write wins
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h4; req_wdata = 32'h8;
    misc_we = 1'b1; misc_wdata = 64'h0003_0000_0000_0000;
    m_cfg = 32'h8;
    @(negedge clk);
    req_valid = 1'b0; misc_we = 1'b0;
    check("R7 conflict err", {63'd0, rsp_err}, 64'd0);
    check_state("R7 conflict");
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [11:0] a;
      logic [31:0] d;
      op = int'($urandom % 8);
      case ($urandom % 6)
        0, 1: a = 12'h4;
        2:    a = 12'h0;
        3:    a = 12'h8;
        4:    a = 12'h6;
        default: a = 12'(($urandom % 1024) * 4);
      endcase
      d = ($urandom % 3 == 0) ? 32'h0 : $urandom;
      if (op < 2) misc_write(1'($urandom), 1'($urandom), "R7 random misc");
      else xfer(1'(op & 1), a, d, int'($urandom % 3), "R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule